// File: doc/BRIEF.md
# Deferred Fault Tag Register File and Execute Stage

This block pairs a register file with a single-cycle execute stage. Next to its data word, every register holds a one-bit poison tag. A load that the compiler hoisted above its guarding branch is issued as a speculative load. If that load meets a memory fault, it does not trap. It writes its destination with the tag set and the data cleared to zero. Arithmetic on a tagged value carries the tag forward into its result, so a failed speculation stays visible along the whole dependence chain. A later check instruction then settles it.

A check on a tagged register sends a redirect to the recovery address supplied with the instruction. A check on a clean register does nothing. A normal load that faults raises the exception output at once. A store that would let poisoned data or a poisoned address reach memory also raises the exception output at once.

Instructions arrive one per clock. The memory request, exception and redirect outputs are combinational from the instruction presented in that cycle. Register updates land on the next rising edge. A read-only peek port exposes any register's data and tag.

Top module: `spec_tag_core`

## Requirements
- R1: After synchronous reset, every register reads data 0 with its tag clear, and with no instruction presented the outputs exc_valid, redirect_valid and mem_we are all 0.
- R2: The opcode field op_code is encoded as 0 none, 1 add, 2 subtract (rs1 minus rs2), 3 bitwise and, 4 load, 5 speculative load, 6 store, 7 check. An add, subtract or and writes its result to rd on the next edge, and the tag it writes is the OR of the two source tags.
- R3: An arithmetic result whose two sources are clean, or a non-faulting load whose address register is clean, leaves the destination tag clear.
- R4: A speculative load whose memory access faults writes rd with data 0 and tag set, and does not assert exc_valid.
- R5: A speculative load whose address register (rs1) is tagged writes rd with data 0 and tag set, whether or not the memory faults.
- R6: A normal load whose access faults asserts exc_valid in that cycle and leaves rd's data and tag unchanged.
- R7: A normal load whose address register is tagged asserts exc_valid and leaves rd unchanged.
- R8: A store with clean rs1 and rs2 asserts mem_we, with mem_addr equal to rs1's data and mem_wdata equal to rs2's data. Loads also present rs1's data on mem_addr.
- R9: A store with either source tagged asserts exc_valid and keeps mem_we low.
- R10: A check whose rs1 is tagged asserts redirect_valid with redirect_addr equal to op_target in that cycle.
- R11: A check whose rs1 is clean asserts neither redirect_valid nor exc_valid and changes no register.
- R12: While op_valid is low, no register changes and exc_valid, redirect_valid and mem_we stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An instruction is presented this cycle |
| op_code | input | 3 | Operation selector |
| op_rd | input | 4 | Destination register index |
| op_rs1 | input | 4 | First source / address register index |
| op_rs2 | input | 4 | Second source / store data register index |
| op_target | input | 32 | Recovery address for a check |
| mem_rdata | input | 32 | Load data from memory |
| mem_fault | input | 1 | Memory reports a fault for this access |
| mem_addr | output | 32 | Access address (rs1 data) |
| mem_wdata | output | 32 | Store data (rs2 data) |
| mem_we | output | 1 | Store write enable |
| exc_valid | output | 1 | Immediate exception |
| redirect_valid | output | 1 | Control redirect to recovery code |
| redirect_addr | output | 32 | Redirect target |
| peek_idx | input | 4 | Register index for the peek port |
| peek_data | output | 32 | Data of register peek_idx |
| peek_tag | output | 1 | Tag of register peek_idx |

## Verification
Two things can meet in one cycle: tag propagation into a register and the read of that same register as a source. This happens when an arithmetic operation or a speculative load names the same register as rd and rs1. The old tag must feed the OR, and the new value must appear only after the edge. Directed cases provoke this by reusing a poisoned register as both source and destination. The random stream draws register indices from a small range, so overlaps are frequent. Each case is judged by peeking the destination after the edge and comparing it with a bench model that updates only after the clock.

// File: rtl/tagx_pkg.sv
package tagx_pkg;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ADD = 3'd1,
        OP_SUB = 3'd2,
        OP_AND = 3'd3,
        OP_LD  = 3'd4,
        OP_LDS = 3'd5,
        OP_ST  = 3'd6,
        OP_CHK = 3'd7
    } op_e;

    typedef struct packed {
        logic alu;
        logic load;
        logic spec;
        logic store;
        logic check;
    } dec_t;

    function automatic dec_t decode(op_e op);
        dec_t d;
        d.alu   = (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND);
        d.load  = (op == OP_LD) || (op == OP_LDS);
        d.spec  = (op == OP_LDS);
        d.store = (op == OP_ST);
        d.check = (op == OP_CHK);
        return d;
    endfunction

endpackage

// File: rtl/tagx_regfile.sv
module tagx_regfile #(
    parameter int unsigned NREG = 16,
    parameter int unsigned DW   = 32,
    localparam int unsigned IW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IW-1:0]   ra_idx,
    output logic [DW-1:0]   ra_data,
    output logic            ra_tag,
    input  logic [IW-1:0]   rb_idx,
    output logic [DW-1:0]   rb_data,
    output logic            rb_tag,
    input  logic [IW-1:0]   rp_idx,
    output logic [DW-1:0]   rp_data,
    output logic            rp_tag,
    input  logic            we,
    input  logic [IW-1:0]   w_idx,
    input  logic [DW-1:0]   w_data,
    input  logic            w_tag,
    output logic [NREG-1:0] tag_vec
);

    logic [DW-1:0]   data_q [NREG];
    logic [NREG-1:0] tag_q;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                data_q[g] <= '0;
                tag_q[g]  <= 1'b0;
            end else if (we && (w_idx == IW'(g))) begin
                data_q[g] <= w_data;
                tag_q[g]  <= w_tag;
            end
        end
    end

    assign ra_data = data_q[ra_idx];
    assign ra_tag  = tag_q[ra_idx];
    assign rb_data = data_q[rb_idx];
    assign rb_tag  = tag_q[rb_idx];
    assign rp_data = data_q[rp_idx];
    assign rp_tag  = tag_q[rp_idx];
    assign tag_vec = tag_q;

    // R2: a write lands with the tag it was given
    a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> (tag_q[$past(w_idx)] == $past(w_tag)) && (data_q[$past(w_idx)] == $past(w_data)));

endmodule

// File: rtl/tagx_exec.sv
module tagx_exec
    import tagx_pkg::*;
#(
    parameter int unsigned DW = 32,
    parameter int unsigned AW = 32,
    parameter int unsigned IW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid,
    input  op_e           op,
    input  logic [IW-1:0] rd,
    input  logic [DW-1:0] a,
    input  logic          ta,
    input  logic [DW-1:0] b,
    input  logic          tb,
    input  logic [AW-1:0] target,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_fault,
    output logic          we,
    output logic [IW-1:0] w_idx,
    output logic [DW-1:0] w_data,
    output logic          w_tag,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic          exc,
    output logic          redir,
    output logic [AW-1:0] redir_addr
);

    dec_t          dec;
    logic [DW-1:0] alu_res;
    logic          bad_addr;
    logic          src_poison;

    assign dec        = decode(op);
    assign bad_addr   = mem_fault || ta;
    assign src_poison = ta || tb;

    always_comb begin
        unique case (op)
            OP_ADD:  alu_res = a + b;
            OP_SUB:  alu_res = a - b;
            OP_AND:  alu_res = a & b;
            default: alu_res = '0;
        endcase
    end

    always_comb begin
        we     = 1'b0;
        w_data = '0;
        w_tag  = 1'b0;
        exc    = 1'b0;
        mem_we = 1'b0;
        redir  = 1'b0;
        if (valid) begin
            if (dec.alu) begin
                we     = 1'b1;
                w_data = alu_res;
                w_tag  = src_poison;
            end else if (dec.load) begin
                if (!bad_addr) begin
                    we     = 1'b1;
                    w_data = mem_rdata;
                end else if (dec.spec) begin
                    we    = 1'b1;
                    w_tag = 1'b1;
                end else begin
                    exc = 1'b1;
                end
            end else if (dec.store) begin
                mem_we = !src_poison;
                exc    = src_poison;
            end else if (dec.check) begin
                redir = ta;
            end
        end
    end

    assign w_idx      = rd;
    assign mem_addr   = AW'(a);
    assign mem_wdata  = b;
    assign redir_addr = target;

    // R9: a poisoned store never reaches memory
    a_r9_store_blocked: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !exc && !redir);

    // R4: a speculative load never raises the exception
    a_r4_spec_silent: assert property (@(posedge clk) disable iff (rst)
        (valid && dec.spec) |-> !exc);

endmodule

// File: rtl/spec_tag_core.sv
module spec_tag_core
    import tagx_pkg::*;
#(
    parameter int unsigned NREG = 16,
    parameter int unsigned DW   = 32,
    parameter int unsigned AW   = 32,
    localparam int unsigned IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  logic [2:0]    op_code,
    input  logic [IW-1:0] op_rd,
    input  logic [IW-1:0] op_rs1,
    input  logic [IW-1:0] op_rs2,
    input  logic [AW-1:0] op_target,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_fault,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic          exc_valid,
    output logic          redirect_valid,
    output logic [AW-1:0] redirect_addr,
    input  logic [IW-1:0] peek_idx,
    output logic [DW-1:0] peek_data,
    output logic          peek_tag
);

    op_e             op;
    logic [DW-1:0]   a_data, b_data, w_data;
    logic            a_tag, b_tag, w_tag, we;
    logic [IW-1:0]   w_idx;
    logic [NREG-1:0] tag_vec;

    assign op = op_e'(op_code);

    tagx_regfile #(.NREG(NREG), .DW(DW)) i_rf (
        .clk    (clk),
        .rst    (rst),
        .ra_idx (op_rs1),
        .ra_data(a_data),
        .ra_tag (a_tag),
        .rb_idx (op_rs2),
        .rb_data(b_data),
        .rb_tag (b_tag),
        .rp_idx (peek_idx),
        .rp_data(peek_data),
        .rp_tag (peek_tag),
        .we     (we),
        .w_idx  (w_idx),
        .w_data (w_data),
        .w_tag  (w_tag),
        .tag_vec(tag_vec)
    );

    tagx_exec #(.DW(DW), .AW(AW), .IW(IW)) i_exec (
        .clk       (clk),
        .rst       (rst),
        .valid     (op_valid),
        .op        (op),
        .rd        (op_rd),
        .a         (a_data),
        .ta        (a_tag),
        .b         (b_data),
        .tb        (b_tag),
        .target    (op_target),
        .mem_rdata (mem_rdata),
        .mem_fault (mem_fault),
        .we        (we),
        .w_idx     (w_idx),
        .w_data    (w_data),
        .w_tag     (w_tag),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .exc       (exc_valid),
        .redir     (redirect_valid),
        .redir_addr(redirect_addr)
    );

    // R4: a faulting speculative load poisons its destination
    a_r4_spec_poison: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == OP_LDS && mem_fault) |=> tag_vec[$past(op_rd)]);

    // R6: a faulting normal load changes no tag
    a_r6_no_tag_change: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == OP_LD && mem_fault) |=> $stable(tag_vec));

    // R11: a check never alters the tags
    a_r11_check_stable: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op == OP_CHK) |=> $stable(tag_vec));

    // R10: a redirect comes alone
    a_r10_redirect_alone: assert property (@(posedge clk) disable iff (rst)
        redirect_valid |-> !exc_valid && !mem_we);

    // R12: idle cycles are quiet and keep state
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !op_valid |-> !exc_valid && !redirect_valid && !mem_we);
    a_r12_idle_keeps: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(tag_vec));

endmodule

// File: tb/test_spec_tag_core.sv
module test_spec_tag_core;

    localparam int NREG = 16;
    localparam int DW   = 32;
    localparam int AW   = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          op_valid = 1'b0;
    logic [2:0]    op_code = '0;
    logic [3:0]    op_rd = '0, op_rs1 = '0, op_rs2 = '0;
    logic [AW-1:0] op_target = '0;
    logic [DW-1:0] mem_rdata = '0;
    logic          mem_fault = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_we, exc_valid, redirect_valid;
    logic [AW-1:0] redirect_addr;
    logic [3:0]    peek_idx = '0;
    logic [DW-1:0] peek_data;
    logic          peek_tag;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [DW-1:0] m_data [NREG];
    logic          m_tag  [NREG];

    always #10 clk = ~clk;

    spec_tag_core i_spec_tag_core (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .op_rd(op_rd), .op_rs1(op_rs1), .op_rs2(op_rs2), .op_target(op_target),
        .mem_rdata(mem_rdata), .mem_fault(mem_fault), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .exc_valid(exc_valid),
        .redirect_valid(redirect_valid), .redirect_addr(redirect_addr),
        .peek_idx(peek_idx), .peek_data(peek_data), .peek_tag(peek_tag)
    );

    task automatic cmp(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic peek(int i, string req);
        peek_idx = 4'(i);
        #1;
        cmp(req, $sformatf("r%0d data", i), 64'(peek_data), 64'(m_data[i]));
        cmp(req, $sformatf("r%0d tag", i), 64'(peek_tag), 64'(m_tag[i]));
    endtask

    function automatic logic [DW-1:0] alu_ref(int op, logic [DW-1:0] a, logic [DW-1:0] b);
        case (op)
            1: return a + b;
            2: return a - b;
            3: return a & b;
            default: return '0;
        endcase
    endfunction

    // drive one instruction, check its same-cycle outputs, update model, peek rd
    task automatic issue(bit v, int op, int rd, int rs1, int rs2,
                         logic [AW-1:0] tgt, logic [DW-1:0] rdat, bit flt);
        logic ta, tb, e_exc, e_red, e_we, upd, n_tag;
        logic [DW-1:0] n_data;
        string rq;
        @(negedge clk);
        op_valid = v; op_code = 3'(op); op_rd = 4'(rd); op_rs1 = 4'(rs1);
        op_rs2 = 4'(rs2); op_target = tgt; mem_rdata = rdat; mem_fault = flt;
        ta = m_tag[rs1]; tb = m_tag[rs2];
        e_exc = v && ((op == 4 && (flt || ta)) || (op == 6 && (ta || tb)));
        e_red = v && op == 7 && ta;
        e_we  = v && op == 6 && !(ta || tb);
        upd = 0; n_data = '0; n_tag = 0;
        if (v && op >= 1 && op <= 3) begin
            upd = 1; n_data = alu_ref(op, m_data[rs1], m_data[rs2]); n_tag = ta || tb;
            rq = (ta || tb) ? "R2" : "R3";
        end else if (v && op == 4) begin
            upd = !(flt || ta); n_data = rdat;
            rq = (flt || ta) ? (ta ? "R7" : "R6") : "R3";
        end else if (v && op == 5) begin
            upd = 1; n_data = (flt || ta) ? '0 : rdat; n_tag = flt || ta;
            rq = ta ? "R5" : (flt ? "R4" : "R3");
        end else if (v && op == 6) begin
            rq = (ta || tb) ? "R9" : "R8";
        end else if (v && op == 7) begin
            rq = ta ? "R10" : "R11";
        end else begin
            rq = "R12";
        end
        #5;
        cmp(rq, "exc_valid", 64'(exc_valid), 64'(e_exc));
        cmp(rq, "redirect_valid", 64'(redirect_valid), 64'(e_red));
        cmp(rq, "mem_we", 64'(mem_we), 64'(e_we));
        if (e_red) cmp("R10", "redirect_addr", 64'(redirect_addr), 64'(tgt));
        if (v && (op == 4 || op == 5 || op == 6))
            cmp("R8", "mem_addr", 64'(mem_addr), 64'(m_data[rs1]));
        if (e_we) cmp("R8", "mem_wdata", 64'(mem_wdata), 64'(m_data[rs2]));
        @(posedge clk);
        if (upd) begin m_data[rd] = n_data; m_tag[rd] = n_tag; end
        #1;
        peek(rd, rq);
        if (!v) op_valid = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int unused;
        unused = $urandom(32'd2024);
        for (int i = 0; i < NREG; i++) begin m_data[i] = '0; m_tag[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        for (int i = 0; i < NREG; i++) peek(i, "R1");
        cmp("R1", "exc_valid", 64'(exc_valid), 64'd0);
        cmp("R1", "redirect_valid", 64'(redirect_valid), 64'd0);
        cmp("R1", "mem_we", 64'(mem_we), 64'd0);

        // directed corner cases
        issue(1, 4, 1, 0, 0, '0, 32'd5, 0);            // R3 load r1=5
        issue(1, 4, 2, 0, 0, '0, 32'd3, 0);            // load r2=3
        issue(1, 1, 3, 1, 2, '0, '0, 0);               // R2 add r3=8
        issue(1, 2, 7, 2, 1, '0, '0, 0);               // R2 sub wraps
        issue(1, 5, 4, 1, 0, '0, 32'hDEAD, 1);         // R4 faulting spec load
        issue(1, 1, 5, 4, 1, '0, '0, 0);               // R2 poison flows
        issue(1, 3, 4, 4, 2, '0, '0, 0);               // rd==rs1 poisoned
        issue(1, 7, 0, 5, 0, 32'h1000_0040, '0, 0);    // R10 check taken
        issue(1, 7, 0, 3, 0, 32'h1000_0080, '0, 0);    // R11 check clean
        issue(1, 4, 3, 1, 0, '0, 32'h77, 1);           // R6 load fault
        issue(1, 4, 3, 4, 0, '0, 32'h77, 0);           // R7 tagged address
        issue(1, 5, 6, 4, 0, '0, 32'h99, 0);           // R5 spec via tagged addr
        issue(1, 6, 0, 1, 2, '0, '0, 0);               // R8 clean store
        issue(1, 6, 0, 1, 5, '0, '0, 0);               // R9 tagged data
        issue(1, 6, 0, 5, 1, '0, '0, 0);               // R9 tagged address
        issue(0, 4, 1, 0, 0, '0, 32'h55, 1);           // R12 idle
        issue(1, 1, 5, 1, 2, '0, '0, 0);               // R3 tag cleared
        issue(1, 5, 4, 4, 0, '0, 32'h12, 0);           // R5 rd==rs1

        // constrained random stream over a few registers
        for (int k = 0; k < 600; k++) begin
            issue(($urandom % 8) != 0, int'($urandom % 8), int'($urandom % 6),
                  int'($urandom % 6), int'($urandom % 6), AW'($urandom),
                  DW'($urandom), ($urandom % 4) == 0);
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule